// File: doc/BRIEF.md
# Descending Channel Scan Sequencer

This block chooses the analog input channel for every conversion of a multi-conversion acquisition. A command register holds a channel field and an active-low scan-enable bit. With scanning off, every conversion uses the channel in the field. With scanning on, the field is the highest channel of the scan. Successive conversions then step down through the channels to channel 0, and after channel 0 the scan starts again at the top.

The sequencer presents the channel for the next conversion on a registered output, so the multiplexer can settle ahead of the conversion. A conversion-start pulse does two things. It latches the presented channel as the channel of that conversion and raises a valid flag for one cycle. It also advances the presented channel. A write to the command register puts the new field value on the output and restarts any scan from its top.

Top module: `chan_scan_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, `mux_chan` is 0, `conv_chan` is 0 and `conv_valid` is 0. The command register comes out of reset in fixed-channel mode (`cmd_scan_n`=1) with a field of 0.
- R2: In fixed-channel mode (last written `cmd_scan_n`=1), a conversion-start pulse leaves `mux_chan` equal to the stored field.
- R3: In scan mode (last written `cmd_scan_n`=0), a conversion-start pulse while `mux_chan` is above 0 lowers `mux_chan` by exactly one.
- R4: In scan mode, a conversion-start pulse while `mux_chan` is 0 reloads `mux_chan` with the stored field, which is the top of the scan.
- R5: In scan mode with a stored field of 0, every conversion uses channel 0 and `mux_chan` stays 0.
- R6: One cycle after a conversion-start pulse, `conv_valid` is 1 and `conv_chan` holds the value `mux_chan` had in the cycle of the pulse. In any cycle not preceded by a pulse, `conv_valid` is 0.
- R7: A command write (`cmd_wr`=1) stores `cmd_chan` and `cmd_scan_n`. One cycle later `mux_chan` equals the written `cmd_chan`.
- R8: When a command write and a conversion-start pulse fall in the same cycle, the conversion uses the channel presented before the write. `mux_chan` then takes the newly written field and does not step.
- R9: In a cycle with neither a write nor a pulse, `mux_chan` does not change.
- R10: A scan with top N converts channels N, N-1, ... 0 and then N again, for every N from 1 to 15. For example, top 3 gives 3, 2, 1, 0, 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_chan | input | CH_W | Channel field: fixed channel, or top of the scan |
| cmd_scan_n | input | 1 | Scan enable, active low (0 = scan, 1 = fixed) |
| conv_start | input | 1 | Conversion-start pulse, one cycle |
| mux_chan | output | CH_W | Channel presented for the next conversion |
| conv_chan | output | CH_W | Channel latched for the conversion just started |
| conv_valid | output | 1 | One-cycle flag that `conv_chan` was just latched |

## Verification
A command write and a conversion-start pulse can land in the same cycle. The write reloads the presented channel, while the pulse captures it and would also step it. The bench provokes this in the middle of a scan by raising both strobes on one clock with a new field and mode. It expects `conv_chan` to carry the channel presented before the write, and `mux_chan` to carry the newly written field with no decrement. The bench then continues the sweep and checks that the scan descends from the new top.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Meaning of the stored active-low scan-enable bit
  typedef enum logic {
    MODE_SCAN  = 1'b0,
    MODE_FIXED = 1'b1
  } scan_mode_e;

endpackage

// File: rtl/scan_cfg_reg.sv
module scan_cfg_reg
  import scan_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [CH_W-1:0] chan_in,
  input  logic            scan_n_in,
  output logic [CH_W-1:0] top_chan,
  output scan_mode_e      mode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      top_chan <= '0;
      mode     <= MODE_FIXED;
    end else if (wr) begin
      top_chan <= chan_in;
      mode     <= scan_mode_e'(scan_n_in);
    end
  end

endmodule

// File: rtl/scan_step.sv
module scan_step
  import scan_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  scan_mode_e      mode,
  input  logic [CH_W-1:0] top_chan,
  input  logic [CH_W-1:0] cur_chan,
  output logic [CH_W-1:0] nxt_chan
);

  localparam logic [CH_W-1:0] ONE = {{(CH_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (mode == MODE_FIXED) begin
      nxt_chan = top_chan;
    end else if (cur_chan == '0) begin
      nxt_chan = top_chan;              // wrap to the top of the scan
    end else begin
      nxt_chan = cur_chan - ONE;        // descend one channel
    end
  end

endmodule

// File: rtl/scan_capture.sv
module scan_capture #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CH_W-1:0] cur_chan,
  output logic [CH_W-1:0] conv_chan,
  output logic            conv_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_chan  <= '0;
      conv_valid <= 1'b0;
    end else begin
      conv_valid <= start;
      if (start) begin
        conv_chan <= cur_chan;
      end
    end
  end

endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
  import scan_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_wr,
  input  logic [CH_W-1:0] cmd_chan,
  input  logic            cmd_scan_n,
  input  logic            conv_start,
  output logic [CH_W-1:0] mux_chan,
  output logic [CH_W-1:0] conv_chan,
  output logic            conv_valid
);

  logic [CH_W-1:0] top_chan;
  scan_mode_e      mode;
  logic [CH_W-1:0] cur_chan;
  logic [CH_W-1:0] nxt_chan;

  scan_cfg_reg #(.CH_W(CH_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr        (cmd_wr),
    .chan_in   (cmd_chan),
    .scan_n_in (cmd_scan_n),
    .top_chan  (top_chan),
    .mode      (mode)
  );

  scan_step #(.CH_W(CH_W)) u_step (
    .mode     (mode),
    .top_chan (top_chan),
    .cur_chan (cur_chan),
    .nxt_chan (nxt_chan)
  );

  // A write takes precedence over stepping; the pulse still captures cur_chan.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_chan <= '0;
    end else if (cmd_wr) begin
      cur_chan <= cmd_chan;
    end else if (conv_start) begin
      cur_chan <= nxt_chan;
    end
  end

  scan_capture #(.CH_W(CH_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .start      (conv_start),
    .cur_chan   (cur_chan),
    .conv_chan  (conv_chan),
    .conv_valid (conv_valid)
  );

  assign mux_chan = cur_chan;

endmodule

// File: rtl/chan_scan_seq_chk.sv
module chan_scan_seq_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_wr,
  input logic [CH_W-1:0] cmd_chan,
  input logic            cmd_scan_n,
  input logic            conv_start,
  input logic [CH_W-1:0] mux_chan,
  input logic [CH_W-1:0] conv_chan,
  input logic            conv_valid
);

  localparam logic [CH_W-1:0] ONE = {{(CH_W-1){1'b0}}, 1'b1};

  // Shadow of the command register, rebuilt from port traffic
  logic [CH_W-1:0] sh_top;
  logic            sh_scan;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_top  <= '0;
      sh_scan <= 1'b0;
    end else if (cmd_wr) begin
      sh_top  <= cmd_chan;
      sh_scan <= ~cmd_scan_n;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (mux_chan == '0 && conv_chan == '0 && !conv_valid));

  assert_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    (conv_start && !cmd_wr && !sh_scan) |=> mux_chan == $past(sh_top));

  assert_descend_R3: assert property (@(posedge clk) disable iff (rst)
    (conv_start && !cmd_wr && sh_scan && mux_chan != '0)
      |=> mux_chan == ($past(mux_chan) - ONE));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (conv_start && !cmd_wr && sh_scan && mux_chan == '0)
      |=> mux_chan == $past(sh_top));

  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> (conv_valid && conv_chan == $past(mux_chan)));

  assert_nopulse_R6: assert property (@(posedge clk) disable iff (rst)
    !conv_start |=> !conv_valid);

  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> mux_chan == $past(cmd_chan));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!cmd_wr && !conv_start) |=> $stable(mux_chan));

endmodule

bind chan_scan_seq chan_scan_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_wr     (cmd_wr),
  .cmd_chan   (cmd_chan),
  .cmd_scan_n (cmd_scan_n),
  .conv_start (conv_start),
  .mux_chan   (mux_chan),
  .conv_chan  (conv_chan),
  .conv_valid (conv_valid)
);

// File: tb/sim_chan_scan_seq.sv
`timescale 1ns/1ps
module sim_chan_scan_seq;

  localparam int CH_W = 4;
  localparam int NCH  = 1 << CH_W;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cmd_wr = 1'b0;
  logic [CH_W-1:0] cmd_chan = '0;
  logic            cmd_scan_n = 1'b1;
  logic            conv_start = 1'b0;
  logic [CH_W-1:0] mux_chan;
  logic [CH_W-1:0] conv_chan;
  logic            conv_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chan_scan_seq #(.CH_W(CH_W)) u0 (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_chan(cmd_chan),
    .cmd_scan_n(cmd_scan_n), .conv_start(conv_start),
    .mux_chan(mux_chan), .conv_chan(conv_chan), .conv_valid(conv_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, then return at the next falling edge
  task automatic cycle(input bit wr, input int ch, input bit scan_n, input bit st);
    @(negedge clk);
    cmd_wr     = wr;
    cmd_chan   = CH_W'(ch);
    cmd_scan_n = scan_n;
    conv_start = st;
    @(negedge clk);
    cmd_wr     = 1'b0;
    conv_start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mux", int'(mux_chan), 0);
    check("R1 valid", int'(conv_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mux after", int'(mux_chan), 0);
    check("R1 conv_chan", int'(conv_chan), 0);
    // Reset mode is fixed, field 0
    cycle(0, 0, 1, 1);
    check("R2 reset fixed", int'(mux_chan), 0);

    for (int top = 0; top < NCH; top++) begin
      // Fixed-channel mode
      cycle(1, top, 1, 0);
      check("R7 fixed load", int'(mux_chan), top);
      for (int k = 0; k < 3; k++) begin
        cycle(0, 0, 1, 1);
        check("R6 fixed conv", int'(conv_chan), top);
        check("R6 valid", int'(conv_valid), 1);
        check("R2 fixed hold", int'(mux_chan), top);
      end
      // Scan mode
      cycle(1, top, 0, 0);
      check("R7 scan load", int'(mux_chan), top);
      for (int k = 0; k < 2 * (top + 1) + 1; k++) begin
        automatic int exp_conv = top - (k % (top + 1));
        automatic int exp_next = (exp_conv == 0) ? top : exp_conv - 1;
        cycle(0, 0, 1, 1);
        check(top == 0 ? "R5 conv" : "R10 conv", int'(conv_chan), exp_conv);
        check(exp_conv == 0 ? "R4 next" : "R3 next", int'(mux_chan), exp_next);
        cycle(0, 0, 1, 0);
        check("R9 idle mux", int'(mux_chan), exp_next);
        check("R6 no pulse", int'(conv_valid), 0);
      end
      // Write and start together mid-scan
      cycle(0, 0, 1, 1);
      begin
        automatic int pres = int'(mux_chan);
        automatic int newtop = (top * 7 + 5) % NCH;
        cycle(1, newtop, 0, 1);
        check("R8 conv old", int'(conv_chan), pres);
        check("R8 mux new", int'(mux_chan), newtop);
        check("R8 valid", int'(conv_valid), 1);
        cycle(0, 0, 1, 1);
        check("R8 conv top", int'(conv_chan), newtop);
        check("R8 then step", int'(mux_chan), newtop == 0 ? 0 : newtop - 1);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule